// File: doc/BRIEF.md
# Half-Bridge Dead-Time Handshake Sequencer

This block sits between two independent PWM commands (one for the high-side FET and one for the low-side FET of a single half-bridge) and the two gate enables. Its job is to keep the two enables from ever being high together. It also places a guaranteed off interval between one FET turning off and the other turning on.

Two sequencing modes are available:
- **Open-loop mode:** the block times the gap from the gate that switched off and holds both enables low until a programmed number of clock cycles has passed.
- **Closed-loop mode:** the block first waits for the gate-voltage comparator of the FET that is turning off to report that FET as off. It then counts the programmed dead interval from that moment. A watchdog bounds this wait. If the comparator never reports off, the block parks both enables low and raises a sticky monitor-fault flag.

Each turn-on also raises a strong-pulldown request on the FET that stays off. This absorbs charge that the switch-node edge couples into that FET's gate. The request is held until a programmable number of cycles after the new gate enable rises.

When both commands are high together, the block treats this as a cross-conduction request. It drives both enables low and latches a sticky shoot-through flag. The two sticky flags clear on single-cycle clear pulses.

Top module: `hb_deadtime_guard`

## Requirements
- R1: If `pwm_hi` and `pwm_lo` are both sampled high at a clock edge, both gate enables are low after that edge; `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: In open-loop mode (`mode_closed`=0), when one side's enable falls at edge f, the opposite enable rises at edge f+N.
  - N = D if the new command arrives at edge f itself.
  - N = max(g+1, D) if the new command is first sampled g≥1 edges after f.
  - D is `dt_code`, or 1 when `dt_code` is 0.
- R3: A `dt_code` of 0 still gives at least one cycle with both enables low between one enable falling and the other rising; an enable only rises in a cycle that follows a cycle with both enables low.
- R4: In closed-loop mode (`mode_closed`=1), a requested enable stays low while the opposite side's off flag (`vgs_off_hi`/`vgs_off_lo`, 1 = that FET is off) is 0.
  - The enable rises at the D-th edge after the first edge that samples the off flag as 1 while waiting.
- R5: In closed-loop mode, if the off flag stays 0 for WD_LIMIT edges of waiting, `mon_flag` is set at that edge. Both enables then stay low until both commands have been sampled low.
- R6: `shoot_flag` is set at the edge after a cross-conduction request and holds until a `clr_shoot` pulse clears it. A set request in the same cycle as a clear wins.
- R7: `pd_lo` (or `pd_hi`) is high from the edge that begins the high-side (or low-side) turn-on sequence until `hold_code` cycles after that side's enable rises. With `hold_code`=0, it falls in the cycle the enable rises. A pulldown request never coincides with its own side's enable.
- R8: During reset all enables, pulldown requests and flags are low. With a command present at reset release, the first enable rises at edge max(2, D) after release.
- R9: An enable is high only in a cycle following an edge at which its own command alone was sampled high. It falls one edge after its command drops.
- R10: `mon_flag` is sticky and clears on a `clr_mon` pulse, with a new fault taking priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | High-side on command |
| pwm_lo | input | 1 | Low-side on command |
| vgs_off_hi | input | 1 | High-side gate comparator: 1 = FET off |
| vgs_off_lo | input | 1 | Low-side gate comparator: 1 = FET off |
| mode_closed | input | 1 | 1 = wait for comparator before dead count, 0 = timed only |
| dt_code | input | DT_W | Dead interval in cycles (0 treated as 1) |
| hold_code | input | HOLD_W | Pulldown hold cycles after enable rise |
| clr_shoot | input | 1 | Clear pulse for shoot_flag |
| clr_mon | input | 1 | Clear pulse for mon_flag |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| pd_hi | output | 1 | Strong pulldown request on high-side gate |
| pd_lo | output | 1 | Strong pulldown request on low-side gate |
| shoot_flag | output | 1 | Sticky cross-conduction request flag |
| mon_flag | output | 1 | Sticky comparator-timeout flag |

## Verification
The assertions guard the following every cycle:
- cross-conduction suppression;
- that an enable only rises out of an all-low cycle;
- that an enable tracks its own command;
- the timeout parking;
- flag setting;
- the pulldown never overlapping its own enable and being present when an enable rises.

The exact lengths of the dead intervals must be measured by the bench's scenarios:
- under each mode, code and idle-gap combination;
- from the comparator edge;
- the watchdog span;
- the pulldown hold length;
- flag stickiness against clear pulses.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_WAIT = 3'd1,
    SQ_DEAD = 3'd2,
    SQ_ON   = 3'd3,
    SQ_MFLT = 3'd4
  } seq_state_e;

  // Effective dead interval: a zero code still yields one cycle.
  function automatic logic [31:0] dead_len(logic [31:0] code);
    return (code == 32'd0) ? 32'd1 : code;
  endfunction

  // True once (elapsed + 1) cycles cover the requested length.
  function automatic logic reached(logic [31:0] elapsed, logic [31:0] len);
    return (elapsed + 32'd1) >= len;
  endfunction

endpackage

// File: rtl/hb_dt_sequencer.sv
module hb_dt_sequencer
  import hb_dt_pkg::*;
#(
  parameter int DT_W     = 6,
  parameter int WD_LIMIT = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pwm,
  input  logic [1:0]      vgs_off,
  input  logic            mode_closed,
  input  logic [DT_W-1:0] dt_code,
  output logic [1:0]      gate,
  output logic [1:0]      turn_on,
  output logic            wd_expire,
  output logic            xc_evt
);
  localparam int WD_W  = $clog2(WD_LIMIT + 1);
  localparam int CNT_W = (DT_W > WD_W) ? DT_W : WD_W;

  seq_state_e       st_q, st_d;
  logic             tgt_q, tgt_d;       // 1 = high side targeted
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DT_W-1:0]  low_q;              // cycles since both enables went low
  logic             cmd_valid, cmd_side, opp_off, dead_done, wd_done;
  logic [31:0]      dlen;
  logic             next_seq_state;

  assign xc_evt    = pwm[1] & pwm[0];
  assign cmd_valid = pwm[1] ^ pwm[0];
  assign cmd_side  = pwm[1];
  assign opp_off   = tgt_q ? vgs_off[0] : vgs_off[1];
  assign dlen      = dead_len(32'(dt_code));
  assign dead_done = mode_closed ? reached(32'(cnt_q), dlen)
                                 : reached(32'(low_q), dlen);
  assign wd_done   = reached(32'(cnt_q), 32'(WD_LIMIT));
  assign next_seq_state = mode_closed;

  always_comb begin
    st_d      = st_q;
    tgt_d     = tgt_q;
    cnt_d     = cnt_q;
    wd_expire = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (cmd_valid) begin
          tgt_d = cmd_side;
          cnt_d = '0;
          st_d  = next_seq_state ? SQ_WAIT : SQ_DEAD;
        end
      end
      SQ_WAIT: begin
        if (!cmd_valid) begin
          st_d = SQ_IDLE;
        end else if (cmd_side != tgt_q) begin
          tgt_d = cmd_side;
          cnt_d = '0;
        end else if (opp_off) begin
          st_d  = SQ_DEAD;
          cnt_d = '0;
        end else if (wd_done) begin
          st_d      = SQ_MFLT;
          wd_expire = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_DEAD: begin
        if (!cmd_valid) begin
          st_d = SQ_IDLE;
        end else if (cmd_side != tgt_q) begin
          tgt_d = cmd_side;
          cnt_d = '0;
          st_d  = next_seq_state ? SQ_WAIT : SQ_DEAD;
        end else if (dead_done) begin
          st_d = SQ_ON;
        end else if (cnt_q != '1) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_ON: begin
        if (!cmd_valid) begin
          st_d = SQ_IDLE;
        end else if (cmd_side != tgt_q) begin
          tgt_d = cmd_side;
          cnt_d = '0;
          st_d  = next_seq_state ? SQ_WAIT : SQ_DEAD;
        end
      end
      SQ_MFLT: begin
        if (pwm == 2'b00) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tgt_q <= 1'b0;
      cnt_q <= '0;
      low_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      if (st_q == SQ_ON)   low_q <= '0;
      else if (low_q != '1) low_q <= low_q + 1'b1;
    end
  end

  assign gate[1]    = (st_q == SQ_ON) &&  tgt_q;
  assign gate[0]    = (st_q == SQ_ON) && !tgt_q;
  assign turn_on[1] = ((st_q == SQ_WAIT) || (st_q == SQ_DEAD)) &&  tgt_q;
  assign turn_on[0] = ((st_q == SQ_WAIT) || (st_q == SQ_DEAD)) && !tgt_q;

  AST_XC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    xc_evt |=> (gate == 2'b00)); // R1
  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate[1]) || $rose(gate[0])) |-> $past(gate == 2'b00)); // R3
  AST_HI_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    gate[1] |-> $past(pwm == 2'b10)); // R9
  AST_LO_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    gate[0] |-> $past(pwm == 2'b01)); // R9
  AST_TIMEOUT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (gate == 2'b00)); // R5

endmodule

// File: rtl/hb_dt_pulldown.sv
module hb_dt_pulldown #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        gate,
  input  logic [1:0]        turn_on,
  input  logic [HOLD_W-1:0] hold_code,
  output logic [1:0]        pd_opp      // [g]: pulldown on the side opposite g
);

  for (genvar g = 0; g < 2; g++) begin : g_side
    logic [HOLD_W-1:0] hcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hcnt_q <= '0;
      else if (!gate[g])       hcnt_q <= '0;
      else if (hcnt_q != '1)   hcnt_q <= hcnt_q + 1'b1;
    end

    assign pd_opp[g] = turn_on[g] | (gate[g] & (hcnt_q < hold_code));

    AST_PD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      pd_opp[g] |-> !gate[1-g]); // R7
    AST_PD_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[g]) |-> $past(pd_opp[g])); // R7
  end

endmodule

// File: rtl/hb_dt_flags.sv
module hb_dt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic xc_evt,
  input  logic wd_expire,
  input  logic clr_shoot,
  input  logic clr_mon,
  output logic shoot_flag,
  output logic mon_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shoot_flag <= 1'b0;
      mon_flag   <= 1'b0;
    end else begin
      if (xc_evt)         shoot_flag <= 1'b1;
      else if (clr_shoot) shoot_flag <= 1'b0;
      if (wd_expire)      mon_flag   <= 1'b1;
      else if (clr_mon)   mon_flag   <= 1'b0;
    end
  end

  AST_SHOOT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    xc_evt |=> shoot_flag); // R6
  AST_SHOOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_shoot && !xc_evt) |=> !shoot_flag); // R6
  AST_MON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> mon_flag); // R10

endmodule

// File: rtl/hb_deadtime_guard.sv
module hb_deadtime_guard #(
  parameter int DT_W     = 6,
  parameter int HOLD_W   = 4,
  parameter int WD_LIMIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_hi,
  input  logic              pwm_lo,
  input  logic              vgs_off_hi,
  input  logic              vgs_off_lo,
  input  logic              mode_closed,
  input  logic [DT_W-1:0]   dt_code,
  input  logic [HOLD_W-1:0] hold_code,
  input  logic              clr_shoot,
  input  logic              clr_mon,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              pd_hi,
  output logic              pd_lo,
  output logic              shoot_flag,
  output logic              mon_flag
);

  logic [1:0] gate_w, turn_on_w, pd_opp_w;
  logic       wd_expire_w, xc_evt_w;

  hb_dt_sequencer #(.DT_W(DT_W), .WD_LIMIT(WD_LIMIT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm         ({pwm_hi, pwm_lo}),
    .vgs_off     ({vgs_off_hi, vgs_off_lo}),
    .mode_closed (mode_closed),
    .dt_code     (dt_code),
    .gate        (gate_w),
    .turn_on     (turn_on_w),
    .wd_expire   (wd_expire_w),
    .xc_evt      (xc_evt_w)
  );

  hb_dt_pulldown #(.HOLD_W(HOLD_W)) u_pd (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate_w),
    .turn_on   (turn_on_w),
    .hold_code (hold_code),
    .pd_opp    (pd_opp_w)
  );

  hb_dt_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .xc_evt     (xc_evt_w),
    .wd_expire  (wd_expire_w),
    .clr_shoot  (clr_shoot),
    .clr_mon    (clr_mon),
    .shoot_flag (shoot_flag),
    .mon_flag   (mon_flag)
  );

  assign gate_hi = gate_w[1];
  assign gate_lo = gate_w[0];
  assign pd_lo   = pd_opp_w[1];   // high side turning on -> hold low side down
  assign pd_hi   = pd_opp_w[0];

endmodule

// File: tb/hb_deadtime_guard_tb_top.sv
module hb_deadtime_guard_tb_top;
  localparam int WD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_b = 2'b00;     // [1] high side, [0] low side
  logic       vgs_off_hi = 1'b0, vgs_off_lo = 1'b0;
  logic       mode_closed = 1'b0;
  logic [5:0] dt_code = 6'd0;
  logic [3:0] hold_code = 4'd0;
  logic       clr_shoot = 1'b0, clr_mon = 1'b0;
  logic       gate_hi, gate_lo, pd_hi, pd_lo, shoot_flag, mon_flag;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  hb_deadtime_guard #(.DT_W(6), .HOLD_W(4), .WD_LIMIT(WD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_b[1]), .pwm_lo(pwm_b[0]),
    .vgs_off_hi(vgs_off_hi), .vgs_off_lo(vgs_off_lo), .mode_closed(mode_closed),
    .dt_code(dt_code), .hold_code(hold_code), .clr_shoot(clr_shoot), .clr_mon(clr_mon),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .pd_hi(pd_hi), .pd_lo(pd_lo),
    .shoot_flag(shoot_flag), .mon_flag(mon_flag));

  // {direction (1 = high to low), dt_code, idle gap edges, expected low cycles}
  localparam int VEC [7][4] = '{
    '{1, 3,  0,  3},   // R2 direct swap
    '{0, 5,  0,  5},   // R2 direct swap, other direction
    '{1, 4,  2,  4},   // R2 gap shorter than code
    '{0, 2,  6,  7},   // R2 gap longer than code
    '{1, 0,  0,  1},   // R3 zero code
    '{0, 1,  0,  1},   // R2 minimum code
    '{1, 6, 10, 11}    // R2 long gap
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gate_of(input int s);
    return (s != 0) ? gate_hi : gate_lo;
  endfunction

  task automatic count_low(input int s, output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (gate_of(s)) break;
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, pdc, src, dst, gap;
    // R8: reset state, command already present
    dt_code = 6'd5; pwm_b = 2'b10;
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {gate_hi, gate_lo, pd_hi, pd_lo, shoot_flag, mon_flag}, 0);
    rst_n = 1'b1;
    count_low(1, n);
    check("R8 first turn-on after reset", n, 4);

    // Table of open-loop swaps
    for (int i = 0; i < 7; i++) begin
      src = VEC[i][0]; dst = 1 - src; gap = VEC[i][2];
      mode_closed = 1'b0; hold_code = 4'd0; dt_code = 6'(VEC[i][1]);
      pwm_b = (src != 0) ? 2'b10 : 2'b01;
      repeat (16) @(negedge clk);
      check("R9 source enabled", gate_of(src), 1);
      pwm_b = (gap == 0) ? ((dst != 0) ? 2'b10 : 2'b01) : 2'b00;
      n = 0;
      for (int j = 1; j < 200; j++) begin
        @(negedge clk);
        if (j == 1) check("R9 source drops", gate_of(src), 0);
        if (gate_of(dst)) break;
        n++;
        if (j == gap) pwm_b = (dst != 0) ? 2'b10 : 2'b01;
      end
      check("R2 R3 dead cycles", n, VEC[i][3]);
    end

    // Closed loop: low side on, request high side
    mode_closed = 1'b1; dt_code = 6'd3; hold_code = 4'd2;
    vgs_off_hi = 1'b1; vgs_off_lo = 1'b0;
    @(negedge clk);
    pwm_b = 2'b10;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      n += int'(gate_hi);
    end
    check("R4 held while monitor on", n, 0);
    check("R7 pulldown during wait", pd_lo, 1);
    vgs_off_lo = 1'b1;
    count_low(1, n);
    check("R4 dead count after monitor", n, 3);
    pdc = int'(pd_lo);
    repeat (5) begin
      @(negedge clk);
      pdc += int'(pd_lo);
    end
    check("R7 pulldown hold cycles", pdc, 2);

    // Watchdog: high side on, request low side, monitor never reports off
    vgs_off_hi = 1'b0;
    pwm_b = 2'b01;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (mon_flag) break;
      n++;
    end
    check("R5 watchdog span", n, WD);
    vgs_off_hi = 1'b1;
    n = 0;
    repeat (6) begin
      @(negedge clk);
      n += int'(gate_lo) + int'(gate_hi);
    end
    check("R5 parked low after timeout", n, 0);
    pwm_b = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 monitor flag sticky", mon_flag, 1);
    clr_mon = 1'b1;
    @(negedge clk);
    clr_mon = 1'b0;
    check("R10 monitor flag cleared", mon_flag, 0);
    pwm_b = 2'b01;
    repeat (10) @(negedge clk);
    check("R5 recovery after release", gate_lo, 1);

    // Cross-conduction request
    mode_closed = 1'b0; dt_code = 6'd2;
    pwm_b = 2'b11;
    @(negedge clk);
    check("R1 both low on cross request", {gate_hi, gate_lo}, 0);
    check("R6 shoot flag set", shoot_flag, 1);
    pwm_b = 2'b01;
    repeat (6) @(negedge clk);
    check("R6 shoot flag sticky", shoot_flag, 1);
    clr_shoot = 1'b1;
    @(negedge clk);
    clr_shoot = 1'b0;
    check("R6 shoot flag cleared", shoot_flag, 0);
    pwm_b = 2'b11; clr_shoot = 1'b1;
    @(negedge clk);
    clr_shoot = 1'b0; pwm_b = 2'b01;
    check("R6 set wins over clear", shoot_flag, 1);
    clr_shoot = 1'b1;
    @(negedge clk);
    clr_shoot = 1'b0;
    repeat (6) @(negedge clk);

    // Pulldown with zero hold
    dt_code = 6'd3; hold_code = 4'd0;
    check("R9 low side on before swap", gate_lo, 1);
    pwm_b = 2'b10;
    @(negedge clk);
    check("R7 pulldown in dead interval", pd_lo, 1);
    count_low(1, n);
    check("R7 zero hold drops at rise", pd_lo, 0);
    check("R7 no pulldown on active side", pd_hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule